// File: doc/BRIEF.md
# Nibble-Addressed Command Register File

This block sits behind a byte-wide serial receiver. Each received command byte is split into a 4-bit register address (low nibble) and a 4-bit data nibble (high nibble). The nibble is written into one of a small set of interface registers:

- a 16-bit hold word, built up one nibble at a time;
- a 10-bit memory address, whose low nibble doubles as a calibration-register select;
- a read-back pointer, whose two low bits are also the top bits of the memory address;
- an analog timeout code and an analog source select;
- a command nibble.

Writing the command nibble fires a one-cycle execute strobe carrying a 3-bit opcode toward a memory and calibration backend. The backend hands read results back on simple return ports. Those results load the hold word and remember the last memory byte.

A combinational read-back byte is always available to the serial transmitter. It is chosen by the pointer. It can show any register, the backend's temperature index, the measured bit-period count, or a fixed link-check pattern.

Top module: `nib_cmd_regfile`

## Requirements
- R1: A command byte is taken only in a cycle with `cmd_valid` high; its bits [3:0] are the register address and bits [7:4] the data nibble. With `cmd_valid` low nothing changes.
- R2: Addresses 0x0, 0x1, 0x2 and 0x3 write hold-word bits [3:0], [7:4], [11:8] and [15:12]; the new value is visible on `hold_word` in the cycle after the byte.
- R3: Address 0x6 writes a nibble that is both `cal_sel` and `mem_addr[3:0]`; address 0x7 writes `mem_addr[7:4]`; address 0x8 writes the pointer, whose bits [1:0] are `mem_addr[9:8]`.
- R4: Address 0xA writes `tmo_code` and address 0xB writes `ana_sel`.
- R5: Address 0x9 stores the command nibble. For nibble values 0 to 7 `exec_stb` is high for exactly the one cycle after the byte, with `exec_op` equal to the nibble.
- R6: Command nibbles 8 to 15 are stored (visible through read-back) but raise no strobe.
- R7: Addresses 0x4, 0x5 and 0xC to 0xF change no register and raise no strobe.
- R8: A cycle with `cal_ret_valid` loads all 16 hold bits from `cal_ret_data`. A cycle with `mem_ret_valid` loads hold [7:0] and the last-memory-byte register from `mem_ret_data`.
- R9: In a collision, a backend return wins over a command-byte nibble write for the hold bits it loads. Nibble writes to other hold bits in that cycle still take effect. If both returns arrive together, calibration data wins in the hold word, while the last-memory-byte register still captures the memory data.
- R10: `rb_byte` is selected by the pointer value:

  | Pointer | `rb_byte` |
  |---|---|
  | 0 | hold [7:0] |
  | 1 | hold [15:8] |
  | 2 | {mem_addr[3:0], cal_sel} |
  | 3 | {command, pointer} |
  | 4 | {ana_sel, tmo_code} |
  | 5 | mem_addr[7:0] |
  | 6 | last memory byte |
  | 7 | `temp_index` |
  | 8 | `bit_period` |

- R11: `rb_byte` is 0x00 for pointer 9 and 0xCA for pointers 10 to 15.
- R12: After reset every register is zero, `exec_stb` is low, and `rb_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_byte | input | 8 | Command byte: [7:4] data, [3:0] address |
| cal_ret_valid | input | 1 | Calibration read result present |
| cal_ret_data | input | 16 | Calibration read result |
| mem_ret_valid | input | 1 | Memory read result present |
| mem_ret_data | input | 8 | Memory read result |
| temp_index | input | 8 | Temperature index shown at pointer 7 |
| bit_period | input | 8 | Bit-period count shown at pointer 8 |
| exec_stb | output | 1 | One-cycle execute strobe |
| exec_op | output | 3 | Opcode qualified by `exec_stb` |
| hold_word | output | 16 | Hold word |
| mem_addr | output | 10 | Memory address |
| cal_sel | output | 4 | Calibration register select |
| tmo_code | output | 4 | Analog timeout code |
| ana_sel | output | 4 | Analog source select |
| rb_byte | output | 8 | Read-back byte |

## Verification
The hold word has two writers that can act in the same cycle: nibble writes from the command stream, and read results returning from the backend. The bench drives a command byte in the very cycle a return pulse arrives. It does this once with the byte aimed at a hold nibble the return covers, and once at a nibble the return leaves alone. It also drives both return kinds together. Each outcome is judged against R9 from the hold word and the read-back byte one cycle later.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NIB_W     = 4;
  localparam int BYTE_W    = 8;
  localparam int HOLD_NIBS = 4;
  localparam int HOLD_W    = NIB_W * HOLD_NIBS;
  localparam int MEM_NIBS  = BYTE_W / NIB_W;
  localparam int MADR_W    = 10;
  localparam int PHI_W     = MADR_W - 2 * NIB_W;
  localparam int OP_W      = NIB_W - 1;
  localparam logic [BYTE_W-1:0] RB_FILL = 8'hCA;

  localparam logic [NIB_W-1:0] ADR_ALO  = 4'h6;
  localparam logic [NIB_W-1:0] ADR_AMID = 4'h7;
  localparam logic [NIB_W-1:0] ADR_PTR  = 4'h8;
  localparam logic [NIB_W-1:0] ADR_CMD  = 4'h9;
  localparam logic [NIB_W-1:0] ADR_TMO  = 4'hA;
  localparam logic [NIB_W-1:0] ADR_ASEL = 4'hB;

  // one write enable per live register
  typedef struct packed {
    logic [HOLD_NIBS-1:0] hold;
    logic alo;
    logic amid;
    logic ptr;
    logic cmd;
    logic tmo;
    logic asel;
  } wr_t;

  typedef struct packed {
    logic [HOLD_W-1:0] hold;
    logic [NIB_W-1:0]  alo;
    logic [NIB_W-1:0]  amid;
    logic [NIB_W-1:0]  ptr;
    logic [NIB_W-1:0]  cmd;
    logic [NIB_W-1:0]  tmo;
    logic [NIB_W-1:0]  asel;
    logic [BYTE_W-1:0] mem_last;
  } regs_t;

  function automatic logic [MADR_W-1:0] mem_addr_of(regs_t r);
    return {r.ptr[PHI_W-1:0], r.amid, r.alo};
  endfunction

  function automatic logic [BYTE_W-1:0] rb_pick(regs_t r,
                                                logic [BYTE_W-1:0] temp,
                                                logic [BYTE_W-1:0] bitp);
    logic [BYTE_W-1:0] v;
    case (r.ptr)
      4'h0:    v = r.hold[BYTE_W-1:0];
      4'h1:    v = r.hold[2*BYTE_W-1:BYTE_W];
      4'h2:    v = {r.alo, r.alo};
      4'h3:    v = {r.cmd, r.ptr};
      4'h4:    v = {r.asel, r.tmo};
      4'h5:    v = {r.amid, r.alo};
      4'h6:    v = r.mem_last;
      4'h7:    v = temp;
      4'h8:    v = bitp;
      4'h9:    v = '0;
      default: v = RB_FILL;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/nib_decode.sv
module nib_decode
  import nib_pkg::*;
(
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output wr_t               wr,
  output logic [NIB_W-1:0]  nib,
  output logic              fire_req
);
  logic [NIB_W-1:0] adr;

  always_comb begin
    adr = in_byte[NIB_W-1:0];
    nib = in_byte[BYTE_W-1:NIB_W];
    wr  = '0;
    for (int i = 0; i < HOLD_NIBS; i++)
      wr.hold[i] = in_valid && (adr == NIB_W'(i));
    wr.alo  = in_valid && (adr == ADR_ALO);
    wr.amid = in_valid && (adr == ADR_AMID);
    wr.ptr  = in_valid && (adr == ADR_PTR);
    wr.cmd  = in_valid && (adr == ADR_CMD);
    wr.tmo  = in_valid && (adr == ADR_TMO);
    wr.asel = in_valid && (adr == ADR_ASEL);
    // only the lower half of the command space executes
    fire_req = wr.cmd && !nib[NIB_W-1];
  end
endmodule

// File: rtl/nib_store.sv
module nib_store
  import nib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_t               wr,
  input  logic [NIB_W-1:0]  nib,
  input  logic              cal_v,
  input  logic [HOLD_W-1:0] cal_d,
  input  logic              mem_v,
  input  logic [BYTE_W-1:0] mem_d,
  output regs_t             regs
);
  logic [HOLD_W-1:0] hold_q;
  logic [NIB_W-1:0]  alo_q, amid_q, ptr_q, cmd_q, tmo_q, asel_q;
  logic [BYTE_W-1:0] mlast_q;

  genvar g;
  generate
    for (g = 0; g < HOLD_NIBS; g++) begin : g_hold
      if (g < MEM_NIBS) begin : g_low
        always_ff @(posedge clk) begin
          if (!rst_n)           hold_q[g*NIB_W +: NIB_W] <= '0;
          else if (cal_v)       hold_q[g*NIB_W +: NIB_W] <= cal_d[g*NIB_W +: NIB_W];
          else if (mem_v)       hold_q[g*NIB_W +: NIB_W] <= mem_d[g*NIB_W +: NIB_W];
          else if (wr.hold[g])  hold_q[g*NIB_W +: NIB_W] <= nib;
        end
      end else begin : g_high
        always_ff @(posedge clk) begin
          if (!rst_n)           hold_q[g*NIB_W +: NIB_W] <= '0;
          else if (cal_v)       hold_q[g*NIB_W +: NIB_W] <= cal_d[g*NIB_W +: NIB_W];
          else if (wr.hold[g])  hold_q[g*NIB_W +: NIB_W] <= nib;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alo_q   <= '0;
      amid_q  <= '0;
      ptr_q   <= '0;
      cmd_q   <= '0;
      tmo_q   <= '0;
      asel_q  <= '0;
      mlast_q <= '0;
    end else begin
      if (wr.alo)  alo_q  <= nib;
      if (wr.amid) amid_q <= nib;
      if (wr.ptr)  ptr_q  <= nib;
      if (wr.cmd)  cmd_q  <= nib;
      if (wr.tmo)  tmo_q  <= nib;
      if (wr.asel) asel_q <= nib;
      if (mem_v)   mlast_q <= mem_d;
    end
  end

  always_comb begin
    regs.hold     = hold_q;
    regs.alo      = alo_q;
    regs.amid     = amid_q;
    regs.ptr      = ptr_q;
    regs.cmd      = cmd_q;
    regs.tmo      = tmo_q;
    regs.asel     = asel_q;
    regs.mem_last = mlast_q;
  end
endmodule

// File: rtl/nib_fire.sv
module nib_fire
  import nib_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_req,
  input  logic [NIB_W-1:0] nib,
  output logic             stb,
  output logic [OP_W-1:0]  op
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb <= 1'b0;
      op  <= '0;
    end else begin
      stb <= fire_req;
      if (fire_req) op <= nib[OP_W-1:0];
    end
  end
endmodule

// File: rtl/nib_cmd_regfile.sv
module nib_cmd_regfile
  import nib_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [BYTE_W-1:0]   cmd_byte,
  input  logic                cal_ret_valid,
  input  logic [HOLD_W-1:0]   cal_ret_data,
  input  logic                mem_ret_valid,
  input  logic [BYTE_W-1:0]   mem_ret_data,
  input  logic [BYTE_W-1:0]   temp_index,
  input  logic [BYTE_W-1:0]   bit_period,
  output logic                exec_stb,
  output logic [OP_W-1:0]     exec_op,
  output logic [HOLD_W-1:0]   hold_word,
  output logic [MADR_W-1:0]   mem_addr,
  output logic [NIB_W-1:0]    cal_sel,
  output logic [NIB_W-1:0]    tmo_code,
  output logic [NIB_W-1:0]    ana_sel,
  output logic [BYTE_W-1:0]   rb_byte
);
  // named internal events for the checker
  wr_t              wr;
  logic [NIB_W-1:0] byte_nib;
  logic             fire_req;
  regs_t            regs;
  logic [NIB_W-1:0] ptr_q;

  nib_decode u_dec (
    .in_valid (cmd_valid),
    .in_byte  (cmd_byte),
    .wr       (wr),
    .nib      (byte_nib),
    .fire_req (fire_req)
  );

  nib_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr),
    .nib   (byte_nib),
    .cal_v (cal_ret_valid),
    .cal_d (cal_ret_data),
    .mem_v (mem_ret_valid),
    .mem_d (mem_ret_data),
    .regs  (regs)
  );

  nib_fire u_fire (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_req (fire_req),
    .nib      (byte_nib),
    .stb      (exec_stb),
    .op       (exec_op)
  );

  always_comb begin
    ptr_q     = regs.ptr;
    hold_word = regs.hold;
    mem_addr  = mem_addr_of(regs);
    cal_sel   = regs.alo;
    tmo_code  = regs.tmo;
    ana_sel   = regs.asel;
    rb_byte   = rb_pick(regs, temp_index, bit_period);
  end
endmodule

// File: rtl/nib_cmd_regfile_chk.sv
module nib_cmd_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [7:0]  cmd_byte,
  input logic        cal_ret_valid,
  input logic [15:0] cal_ret_data,
  input logic        mem_ret_valid,
  input logic        exec_stb,
  input logic [2:0]  exec_op,
  input logic [15:0] hold_word,
  input logic [9:0]  mem_addr,
  input logic [3:0]  tmo_code,
  input logic [3:0]  ana_sel,
  input logic [3:0]  ptr_q,
  input logic [7:0]  rb_byte
);
  // R5: a strobe is always caused by a low-half command byte one cycle earlier
  p_exec_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> ($past(cmd_valid) && $past(cmd_byte[3:0]) == 4'h9 && !$past(cmd_byte[7])));

  p_exec_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> exec_op == $past(cmd_byte[6:4]));

  p_badop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[3:0] == 4'h9 && cmd_byte[7]) |=> !exec_stb);

  p_reserved_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_byte[3:0] inside {4'h4, 4'h5, 4'hC, 4'hD, 4'hE, 4'hF})
     && !cal_ret_valid && !mem_ret_valid)
    |=> ($stable(hold_word) && $stable(mem_addr) && $stable(tmo_code)
         && $stable(ana_sel) && $stable(ptr_q) && !exec_stb));

  p_top_nib_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[3:0] == 4'h3 && !cal_ret_valid)
    |=> hold_word[15:12] == $past(cmd_byte[7:4]));

  p_cal_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ret_valid |=> hold_word == $past(cal_ret_data));

  p_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q >= 4'hA) |-> rb_byte == 8'hCA);
endmodule

bind nib_cmd_regfile nib_cmd_regfile_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_byte      (cmd_byte),
  .cal_ret_valid (cal_ret_valid),
  .cal_ret_data  (cal_ret_data),
  .mem_ret_valid (mem_ret_valid),
  .exec_stb      (exec_stb),
  .exec_op       (exec_op),
  .hold_word     (hold_word),
  .mem_addr      (mem_addr),
  .tmo_code      (tmo_code),
  .ana_sel       (ana_sel),
  .ptr_q         (ptr_q),
  .rb_byte       (rb_byte)
);

// File: tb/test_nib_cmd_regfile.sv
module test_nib_cmd_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        cal_ret_valid = 1'b0;
  logic [15:0] cal_ret_data = '0;
  logic        mem_ret_valid = 1'b0;
  logic [7:0]  mem_ret_data = '0;
  logic [7:0]  temp_index = 8'h41;
  logic [7:0]  bit_period = 8'h55;
  logic        exec_stb;
  logic [2:0]  exec_op;
  logic [15:0] hold_word;
  logic [9:0]  mem_addr;
  logic [3:0]  cal_sel, tmo_code, ana_sel;
  logic [7:0]  rb_byte;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  nib_cmd_regfile i_nib_cmd_regfile (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cal_ret_valid(cal_ret_valid), .cal_ret_data(cal_ret_data),
    .mem_ret_valid(mem_ret_valid), .mem_ret_data(mem_ret_data),
    .temp_index(temp_index), .bit_period(bit_period),
    .exec_stb(exec_stb), .exec_op(exec_op), .hold_word(hold_word),
    .mem_addr(mem_addr), .cal_sel(cal_sel), .tmo_code(tmo_code),
    .ana_sel(ana_sel), .rb_byte(rb_byte)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one cycle of stimulus, applied at a falling edge; returns at the next falling edge
  task automatic cyc(input logic v, input logic [7:0] b, input logic cv,
                     input logic [15:0] cd, input logic mv, input logic [7:0] md);
    cmd_valid = v; cmd_byte = b;
    cal_ret_valid = cv; cal_ret_data = cd;
    mem_ret_valid = mv; mem_ret_data = md;
    @(negedge clk);
    cmd_valid = 1'b0; cal_ret_valid = 1'b0; mem_ret_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    cyc(1'b1, b, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic read_ptr(input logic [3:0] p, input logic [7:0] exp, input string tag);
    send({p, 4'h8});
    chk(tag, {8'h00, rb_byte}, {8'h00, exp});
  endtask

  task automatic t_reset();
    chk("R12 hold", hold_word, 16'h0);
    chk("R12 addr", {6'h0, mem_addr}, 16'h0);
    chk("R12 strobe", {15'h0, exec_stb}, 16'h0);
    chk("R12 rb", {8'h0, rb_byte}, 16'h0);
    chk("R12 tmo/asel", {8'h0, tmo_code, ana_sel}, 16'h0);
  endtask

  task automatic t_hold();
    send(8'h00); send(8'h41); send(8'hC2); send(8'h83);
    chk("R2 R1 hold word", hold_word, 16'h8C40);
    read_ptr(4'h0, 8'h40, "R10 ptr0");
    read_ptr(4'h1, 8'h8C, "R10 ptr1");
  endtask

  task automatic t_addr();
    send(8'hA6); send(8'h57); send(8'hE8);
    chk("R3 mem_addr", {6'h0, mem_addr}, 16'h025A);
    chk("R3 cal_sel", {12'h0, cal_sel}, 16'h000A);
    chk("R11 ptr E fill", {8'h0, rb_byte}, 16'h00CA);
    send(8'h98);
    chk("R11 ptr9 zero", {8'h0, rb_byte}, 16'h0000);
    chk("R3 ptr low bits", {6'h0, mem_addr}, 16'h015A);
    read_ptr(4'h2, 8'hAA, "R10 ptr2");
    read_ptr(4'h5, 8'h5A, "R10 ptr5");
  endtask

  task automatic t_analog();
    send(8'hCA); send(8'h1B);
    chk("R4 tmo", {12'h0, tmo_code}, 16'h000C);
    chk("R4 asel", {12'h0, ana_sel}, 16'h0001);
    read_ptr(4'h4, 8'h1C, "R10 ptr4");
  endtask

  task automatic t_exec();
    for (int op = 0; op < 8; op++) begin
      send({1'b0, 3'(op), 4'h9});
      chk("R5 strobe high", {15'h0, exec_stb}, 16'h1);
      chk("R5 opcode", {13'h0, exec_op}, 16'(op));
      @(negedge clk);
      chk("R5 strobe one cycle", {15'h0, exec_stb}, 16'h0);
    end
    send(8'h38); send(8'h59);
    chk("R10 ptr3", {8'h0, rb_byte}, 16'h0053);
  endtask

  task automatic t_badop();
    send(8'hD9);
    chk("R6 no strobe", {15'h0, exec_stb}, 16'h0);
    chk("R6 stored", {8'h0, rb_byte}, 16'h00D3);
  endtask

  task automatic t_reserved();
    logic [15:0] h;
    logic [9:0]  a;
    h = hold_word; a = mem_addr;
    send(8'h74); send(8'h75); send(8'h7C); send(8'h7D); send(8'h7E); send(8'h7F);
    chk("R7 hold kept", hold_word, h);
    chk("R7 addr kept", {6'h0, mem_addr}, {6'h0, a});
    chk("R7 analog kept", {8'h0, tmo_code, ana_sel}, 16'h00C1);
    chk("R7 no strobe", {15'h0, exec_stb}, 16'h0);
    chk("R7 rb kept", {8'h0, rb_byte}, 16'h00D3);
    cyc(1'b0, 8'h50, 1'b0, '0, 1'b0, '0);
    chk("R1 invalid ignored", hold_word, h);
  endtask

  task automatic t_returns();
    cyc(1'b0, 8'h00, 1'b1, 16'h1234, 1'b0, '0);
    chk("R8 cal load", hold_word, 16'h1234);
    cyc(1'b0, 8'h00, 1'b0, '0, 1'b1, 8'hAB);
    chk("R8 mem load", hold_word, 16'h12AB);
    read_ptr(4'h6, 8'hAB, "R8 R10 ptr6");
    read_ptr(4'h7, 8'h41, "R10 ptr7");
    read_ptr(4'h8, 8'h55, "R10 ptr8");
  endtask

  task automatic t_collide();
    cyc(1'b1, 8'h30, 1'b0, '0, 1'b1, 8'h77);
    chk("R9 mem over nib0", hold_word, 16'h1277);
    cyc(1'b1, 8'h93, 1'b0, '0, 1'b1, 8'h66);
    chk("R9 nib3 with mem", hold_word, 16'h9266);
    cyc(1'b1, 8'h52, 1'b1, 16'hBEEF, 1'b0, '0);
    chk("R9 cal over nib2", hold_word, 16'hBEEF);
    cyc(1'b0, 8'h00, 1'b1, 16'h0102, 1'b1, 8'hFF);
    chk("R9 cal over mem", hold_word, 16'h0102);
    read_ptr(4'h6, 8'hFF, "R9 last mem kept");
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_addr();
    t_analog();
    t_exec();
    t_badop();
    t_reserved();
    t_returns();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule